// File: doc/BRIEF.md
# Serial Boot Download Controller

This controller runs once after reset, between a UART receiver/transmitter pair and a 512-byte on-chip RAM. It first sends a single break on the transmit side. It then waits, for as long as it takes, for a first character. That character decides one of three things: hand control straight to nonvolatile memory, run the download at the default bit rate, or run it at the slower 1200-baud rate.

Each byte after the first goes into RAM at the next address, counting up from zero. The same byte is echoed to the host in that cycle. The download ends in one of two ways. Either the host stays silent for about four character times at the chosen rate, or the last RAM location has been written. The controller then pulses a jump request to the RAM base. After any jump request it goes quiet until the next reset.

The UART itself, the processor and any programming helper are outside this block. The receiver must present each byte as a one-cycle strobe. The transmitter must take a byte or a break request in the cycle it is offered.

Top module: `boot_dl_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is low or zero (tx_break, tx_valid, ram_we, baud_slow, jump_valid, and all data and address buses).
- R2: The cycle after the first clock edge with reset released, tx_break is high for exactly one cycle. It does not rise again before the next reset.
- R3: A first character with data 8'h00, or any first strobe with rx_break high, raises jump_valid in the cycle after it is accepted, with jump_addr = 16'hB600. No RAM write happens.
- R4: A first character of 8'hFF, or any value other than 8'h00, 8'hE0 and 8'hC0, leaves baud_slow at 0 and starts the download. The first character is never written to RAM or echoed.
- R5: A first character of 8'hE0 or 8'hC0 sets baud_slow to 1 in the cycle after it is accepted. baud_slow then stays at 1 until reset.
- R6: Each byte accepted during the download shows up in the cycle after acceptance. In that cycle ram_we and tx_valid are both high, ram_wdata and tx_data both equal the byte, and ram_addr equals the number of bytes stored before it, starting from 0.
- R7: At the default rate the idle limit is IDLE_LIMIT cycles (default 10241). If no byte comes on IDLE_LIMIT consecutive clock edges after the last accepted character, jump_valid rises IDLE_LIMIT+1 cycles after that character's output cycle, with jump_addr = 0. Every accepted byte restarts this count.
- R8: At the slow rate the idle limit is ceil(IDLE_LIMIT × 7812 / 1200) cycles (66669 by default), with the same timing as R7.
- R9: When a byte fills the last RAM location (RAM_DEPTH bytes stored), jump_valid rises in the next cycle with jump_addr = 0, without waiting for the idle limit.
- R10: A first character of 8'hFF followed by silence ends with a jump to address 0 and no RAM write at all.
- R11: jump_valid is high for exactly one cycle. After it, strobes on rx_valid cause no RAM write, no echo and no further jump until reset.
- R12: The idle timer does not run before the first character. However long the wait before it, no jump is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is on rx_data |
| rx_data | input | DATA_W | Received character |
| rx_break | input | 1 | The strobed character was a break |
| tx_break | output | 1 | One-cycle request to send a break |
| tx_valid | output | 1 | One-cycle request to send tx_data |
| tx_data | output | DATA_W | Echoed character |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | $clog2(RAM_DEPTH) | RAM write address, offset from the RAM base |
| ram_wdata | output | DATA_W | RAM write data |
| baud_slow | output | 1 | High selects the 1200-baud rate |
| jump_valid | output | 1 | One-cycle jump request |
| jump_addr | output | JUMP_W | Jump target address |

## Verification
The assertions assume that rx_valid is a strobe the UART raises for a single cycle per character, and that the transmitter takes every echo in the cycle it is offered. Under those two assumptions, write addresses counting up with no gaps and echo data equal to write data follow from the design alone. The bench drives every character as a one-cycle strobe set up at the falling edge and cleared at the next falling edge. It keeps gaps between download bytes just inside the idle limit when a byte must be accepted, and leaves silence past the limit only where a timeout is the intended result. It raises rx_break only together with rx_valid.

// File: rtl/boot_dl_pkg.sv
package boot_dl_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_WAIT_FIRST,
    ST_LOAD,
    ST_JUMP,
    ST_DONE
  } ctrl_state_t;

  typedef enum logic [1:0] {
    FC_NONVOL,
    FC_FAST,
    FC_SLOW
  } first_kind_t;

endpackage

// File: rtl/boot_first_char.sv
module boot_first_char
  import boot_dl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] LOOP_CODE   = 8'h00,
  parameter logic [DATA_W-1:0] SLOW_CODE_A = 8'hE0,
  parameter logic [DATA_W-1:0] SLOW_CODE_B = 8'hC0
) (
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_break,
  output first_kind_t       kind
);

  // A break, or a looped-back break read as zero, selects the nonvolatile
  // target. The two distorted codes mean a sync byte sent at the slow rate.
  // Every other value counts as a sync at the default rate.
  always_comb begin
    if (rx_break || rx_data == LOOP_CODE) begin
      kind = FC_NONVOL;
    end else if (rx_data == SLOW_CODE_A || rx_data == SLOW_CODE_B) begin
      kind = FC_SLOW;
    end else begin
      kind = FC_FAST;
    end
  end

endmodule

// File: rtl/boot_idle_timer.sv
module boot_idle_timer #(
  parameter int FAST_LIMIT = 10241,
  parameter int SLOW_LIMIT = 66669,
  localparam int CNT_W = $clog2(SLOW_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  input  logic slow,
  output logic expire
);

  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_LIMIT - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_LIMIT - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last   = slow ? SLOW_LAST : FAST_LAST;
  assign expire = run && !clear && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run || clear) begin
      cnt <= '0;
    end else if (!expire) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/boot_wr_pointer.sv
module boot_wr_pointer #(
  parameter int DEPTH = 512,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  assign at_last = (addr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (advance && !at_last) begin
      addr <= addr + 1'b1;
    end
  end

endmodule

// File: rtl/boot_dl_ctrl.sv
module boot_dl_ctrl
  import boot_dl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RAM_DEPTH  = 512,
  parameter int JUMP_W     = 16,
  parameter logic [JUMP_W-1:0] NV_BASE  = 16'hB600,
  parameter logic [JUMP_W-1:0] RAM_BASE = 16'h0000,
  parameter int IDLE_LIMIT = 10241,
  parameter int FAST_BAUD  = 7812,
  parameter int SLOW_BAUD  = 1200,
  localparam int ADDR_W    = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              tx_break,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              baud_slow,
  output logic              jump_valid,
  output logic [JUMP_W-1:0] jump_addr
);

  // Slow-rate limit scaled by the bit-rate ratio, rounded up.
  localparam int SLOW_LIMIT = (IDLE_LIMIT * FAST_BAUD + SLOW_BAUD - 1) / SLOW_BAUD;

  ctrl_state_t       state;
  first_kind_t       kind;
  logic              load_byte;
  logic              expire;
  logic [ADDR_W-1:0] wr_ptr;
  logic              ptr_last;

  assign load_byte = (state == ST_LOAD) && rx_valid;

  boot_first_char #(
    .DATA_W(DATA_W)
  ) u_first (
    .rx_data (rx_data),
    .rx_break(rx_break),
    .kind    (kind)
  );

  boot_idle_timer #(
    .FAST_LIMIT(IDLE_LIMIT),
    .SLOW_LIMIT(SLOW_LIMIT)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run   (state == ST_LOAD),
    .clear (rx_valid),
    .slow  (baud_slow),
    .expire(expire)
  );

  boot_wr_pointer #(
    .DEPTH(RAM_DEPTH)
  ) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .advance(load_byte),
    .addr   (wr_ptr),
    .at_last(ptr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_INIT;
      tx_break   <= 1'b0;
      tx_valid   <= 1'b0;
      tx_data    <= '0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      baud_slow  <= 1'b0;
      jump_valid <= 1'b0;
      jump_addr  <= '0;
    end else begin
      tx_break   <= 1'b0;
      tx_valid   <= 1'b0;
      ram_we     <= 1'b0;
      jump_valid <= 1'b0;
      unique case (state)
        ST_INIT: begin
          tx_break <= 1'b1;
          state    <= ST_WAIT_FIRST;
        end
        ST_WAIT_FIRST: begin
          if (rx_valid) begin
            unique case (kind)
              FC_NONVOL: begin
                jump_addr <= NV_BASE;
                state     <= ST_JUMP;
              end
              FC_SLOW: begin
                baud_slow <= 1'b1;
                state     <= ST_LOAD;
              end
              default: state <= ST_LOAD;
            endcase
          end
        end
        ST_LOAD: begin
          if (rx_valid) begin
            ram_we    <= 1'b1;
            ram_addr  <= wr_ptr;
            ram_wdata <= rx_data;
            tx_valid  <= 1'b1;
            tx_data   <= rx_data;
            if (ptr_last) begin
              jump_addr <= RAM_BASE;
              state     <= ST_JUMP;
            end
          end else if (expire) begin
            jump_addr <= RAM_BASE;
            state     <= ST_JUMP;
          end
        end
        ST_JUMP: begin
          jump_valid <= 1'b1;
          state      <= ST_DONE;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

endmodule

// File: rtl/boot_dl_checker.sv
module boot_dl_checker #(
  parameter int DATA_W    = 8,
  parameter int RAM_DEPTH = 512,
  parameter int JUMP_W    = 16,
  parameter logic [JUMP_W-1:0] NV_BASE  = 16'hB600,
  parameter logic [JUMP_W-1:0] RAM_BASE = 16'h0000,
  localparam int ADDR_W   = $clog2(RAM_DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_break,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              baud_slow,
  input logic              jump_valid,
  input logic [JUMP_W-1:0] jump_addr
);

  logic [ADDR_W:0] wr_cnt;
  logic            jump_seen;
  logic            break_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt     <= '0;
      jump_seen  <= 1'b0;
      break_seen <= 1'b0;
    end else begin
      if (ram_we) wr_cnt <= wr_cnt + 1'b1;
      if (jump_valid) jump_seen <= 1'b1;
      if (tx_break) break_seen <= 1'b1;
    end
  end

  a_r2_break_once: assert property (@(posedge clk) disable iff (rst)
    tx_break |-> !break_seen);

  a_r3_target_legal: assert property (@(posedge clk) disable iff (rst)
    jump_valid |-> (jump_addr == NV_BASE || jump_addr == RAM_BASE));

  a_r3_nonvol_no_writes: assert property (@(posedge clk) disable iff (rst)
    (jump_valid && jump_addr == NV_BASE) |-> (wr_cnt == '0));

  a_r5_rate_sticky: assert property (@(posedge clk) disable iff (rst)
    baud_slow |=> baud_slow);

  a_r6_echo_matches_write: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (tx_valid && tx_data == ram_wdata));

  a_r6_addr_in_order: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr == wr_cnt[ADDR_W-1:0]));

  a_r9_no_write_past_end: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (wr_cnt < (ADDR_W+1)'(RAM_DEPTH)));

  a_r11_jump_single: assert property (@(posedge clk) disable iff (rst)
    jump_valid |=> !jump_valid);

  a_r11_quiet_after_jump: assert property (@(posedge clk) disable iff (rst)
    jump_seen |-> (!ram_we && !tx_valid && !jump_valid));

endmodule

bind boot_dl_ctrl boot_dl_checker #(
  .DATA_W   (DATA_W),
  .RAM_DEPTH(RAM_DEPTH),
  .JUMP_W   (JUMP_W),
  .NV_BASE  (NV_BASE),
  .RAM_BASE (RAM_BASE)
) u_checker (
  .clk       (clk),
  .rst       (rst),
  .tx_break  (tx_break),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .ram_wdata (ram_wdata),
  .baud_slow (baud_slow),
  .jump_valid(jump_valid),
  .jump_addr (jump_addr)
);

// File: tb/test_boot_dl_ctrl.sv
module test_boot_dl_ctrl;

  localparam int T_DEPTH  = 16;
  localparam int T_LIMIT  = 300;
  localparam int T_SLOW   = (T_LIMIT * 7812 + 1199) / 1200;
  localparam int T_ADDR_W = $clog2(T_DEPTH);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                rx_valid = 1'b0;
  logic [7:0]          rx_data = '0;
  logic                rx_break = 1'b0;
  logic                tx_break;
  logic                tx_valid;
  logic [7:0]          tx_data;
  logic                ram_we;
  logic [T_ADDR_W-1:0] ram_addr;
  logic [7:0]          ram_wdata;
  logic                baud_slow;
  logic                jump_valid;
  logic [15:0]         jump_addr;

  int checks = 0;
  int fails  = 0;
  int wr_seen = 0;
  int jump_seen = 0;

  always #5 clk = ~clk;

  boot_dl_ctrl #(
    .RAM_DEPTH (T_DEPTH),
    .IDLE_LIMIT(T_LIMIT)
  ) i_boot_dl_ctrl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .tx_break(tx_break), .tx_valid(tx_valid),
    .tx_data(tx_data), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .baud_slow(baud_slow), .jump_valid(jump_valid),
    .jump_addr(jump_addr)
  );

  always @(negedge clk) begin
    if (rst) begin
      wr_seen   <= 0;
      jump_seen <= 0;
    end else begin
      if (ram_we) wr_seen <= wr_seen + 1;
      if (jump_valid) jump_seen <= jump_seen + 1;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; rx_valid = 1'b0; rx_break = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic brk);
    rx_valid = 1'b1; rx_data = d; rx_break = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_break = 1'b0;
  endtask

  task automatic send_load(input logic [7:0] d, input int exp_addr);
    send_byte(d, 1'b0);
    check(ram_we && tx_valid, "R6 write and echo strobes", {ram_we, tx_valid}, 2'b11);
    check(ram_addr == T_ADDR_W'(exp_addr), "R6 write address", ram_addr, exp_addr);
    check(ram_wdata == d && tx_data == d, "R6 write/echo data", {ram_wdata, tx_data}, {d, d});
  endtask

  task automatic wait_jump(input int max_cycles, output int k);
    k = 0;
    while (!jump_valid && k < max_cycles) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({tx_break, tx_valid, ram_we, baud_slow, jump_valid} == 5'b0 &&
          tx_data == 0 && ram_addr == 0 && ram_wdata == 0 && jump_addr == 0,
          "R1 outputs in reset", {tx_break, tx_valid, ram_we, baud_slow, jump_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(tx_break == 1'b1, "R2 break pulse", tx_break, 1);
    @(negedge clk);
    check(tx_break == 1'b0, "R2 break ends", tx_break, 0);
    repeat (20) @(negedge clk);
    check(tx_break == 1'b0 && jump_seen == 0, "R2 no repeat", tx_break, 0);
  endtask

  task automatic t_nonvol(input logic [7:0] d, input logic brk);
    int k;
    do_reset();
    send_byte(d, brk);
    check(ram_we == 1'b0 && tx_valid == 1'b0, "R3 no write on first char", ram_we, 0);
    wait_jump(5, k);
    check(k == 1, "R3 jump delay", k, 1);
    check(jump_addr == 16'hB600, "R3 nonvolatile target", jump_addr, 16'hB600);
    @(negedge clk);
    check(jump_valid == 1'b0, "R11 single pulse", jump_valid, 0);
    check(wr_seen == 0, "R3 no writes", wr_seen, 0);
  endtask

  task automatic t_sync_only();
    int k;
    do_reset();
    repeat (3 * T_LIMIT) @(negedge clk);
    check(jump_seen == 0, "R12 no timer before first char", jump_seen, 0);
    send_byte(8'hFF, 1'b0);
    check(baud_slow == 1'b0, "R4 default rate", baud_slow, 0);
    wait_jump(T_SLOW + 10, k);
    check(k == T_LIMIT + 1, "R7 default timeout", k, T_LIMIT + 1);
    check(jump_addr == 16'h0000, "R10 ram target", jump_addr, 0);
    check(wr_seen == 0, "R10 zero bytes stored", wr_seen, 0);
  endtask

  task automatic t_download(input logic [7:0] first);
    int k;
    do_reset();
    send_byte(first, 1'b0);
    check(baud_slow == 1'b0 && ram_we == 1'b0 && tx_valid == 1'b0,
          "R4 first char not stored", {baud_slow, ram_we, tx_valid}, 0);
    for (int i = 0; i < 6; i++) begin
      repeat (T_LIMIT - 2) @(negedge clk);
      send_load(8'(8'hA5 ^ (i * 37)), i);
    end
    check(jump_seen == 0, "R7 bytes reload timer", jump_seen, 0);
    wait_jump(T_SLOW + 10, k);
    check(k == T_LIMIT + 1, "R7 timeout after last byte", k, T_LIMIT + 1);
    check(jump_addr == 16'h0000 && wr_seen == 6, "R7 ram jump after 6 bytes", wr_seen, 6);
  endtask

  task automatic t_slow(input logic [7:0] code);
    int k;
    do_reset();
    send_byte(code, 1'b0);
    check(baud_slow == 1'b1, "R5 slow rate selected", baud_slow, 1);
    repeat (T_SLOW - 2) @(negedge clk);
    send_load(8'h3C, 0);
    check(baud_slow == 1'b1, "R5 slow rate held", baud_slow, 1);
    wait_jump(T_SLOW + 10, k);
    check(k == T_SLOW + 1, "R8 slow timeout", k, T_SLOW + 1);
    check(jump_addr == 16'h0000, "R8 ram target", jump_addr, 0);
  endtask

  task automatic t_full();
    int k;
    do_reset();
    send_byte(8'hFF, 1'b0);
    for (int i = 0; i < T_DEPTH; i++) begin
      repeat (i % 3) @(negedge clk);
      send_load(8'(i * 7 + 3), i);
    end
    wait_jump(5, k);
    check(k == 1, "R9 jump right after full", k, 1);
    check(jump_addr == 16'h0000 && wr_seen == T_DEPTH, "R9 all bytes stored", wr_seen, T_DEPTH);
    @(negedge clk);
    check(jump_valid == 1'b0, "R11 single pulse", jump_valid, 0);
    send_byte(8'h77, 1'b0);
    check(ram_we == 1'b0 && tx_valid == 1'b0, "R11 ignored after jump", {ram_we, tx_valid}, 0);
    send_byte(8'hFF, 1'b0);
    repeat (T_LIMIT + 5) @(negedge clk);
    check(wr_seen == T_DEPTH && jump_seen == 1, "R11 done state holds", jump_seen, 1);
  endtask

  initial begin
    t_reset();
    t_nonvol(8'h00, 1'b0);
    t_nonvol(8'h55, 1'b1);
    t_sync_only();
    t_download(8'hFF);
    t_download(8'h5A);
    t_slow(8'hE0);
    t_slow(8'hC0);
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule